// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block keeps the interrupt state of a two-channel serial controller. Channel A (index 0) and channel B (index 1) each send single-cycle pulses that raise or drop their receive and transmit interrupts, plus a break status level. For each channel and source the block tracks a pending flag and an under-service flag. It keeps one shared modified vector register, assembles an interrupt-pending register, and drives one interrupt request line.

Software commands reach the block as a one-cycle command strobe. The strobe carries the target channel and the command byte; the command field sits in bits 5:3. A shared select bit chooses the high or low vector encoding. The encoding is applied when the vector register is written, not when it is read. A source that is raised does not take over the vector while the other source of the same channel is under service. Its pending flag is still set. All pins are plain control and status pins. Nothing flows through the block as a stream, so no interface needs back-pressure.

Top module: `sio_irq_vector`

## Requirements
- R1: `irq` is high when any of these holds on either channel: the transmit enable is set with transmit pending; the receive mode (2 bits) is 01 or 10 with receive pending; or the break enable is set with break status high. Receive modes 00 and 11 never raise `irq`.
- R2: A raised receive interrupt marks receive under service and writes the vector only if transmit of that channel is not under service. The reverse rule applies to a raised transmit interrupt. Both sources of one channel are never under service together, and a source under service is always pending.
- R3: With `vec_hi_sel`=1 the vector codes are: receive A 0x30, transmit A 0x10, receive B 0x20, transmit B 0x00, no interrupt 0x60.
- R4: With `vec_hi_sel`=0 the vector codes are: receive A 0x0C, transmit A 0x08, receive B 0x04, transmit B 0x00, no interrupt 0x06. A stored vector keeps its code when `vec_hi_sel` changes later.
- R5: The pending register has receive A at bit 5, transmit A at bit 4, receive B at bit 2 and transmit B at bit 1. Bits 3 and 0 (external/status) read 0 and bits 7:6 read 0. A bit is set when its interrupt is raised and cleared when that interrupt is cleared.
- R6: A command field of 3'b111 (byte 0x38) clears the receive interrupt of the addressed channel if receive is under service. Otherwise it clears the transmit interrupt if transmit is under service, and otherwise it does nothing. A field of 3'b101 (byte 0x28) clears that channel's transmit interrupt. Other fields have no effect.
- R7: Any interrupt clear writes the no-interrupt code for the `vec_hi_sel` value of that cycle into the vector.
- R8: `rd_data` shows the vector when `rd_idx`=2 and the pending register when `rd_idx`=3. Any other index reads 0. The read is combinational.
- R9: A `chan_rst` pulse clears that channel's pending and under-service flags and its pending-register bits. It leaves the vector and the other channel unchanged.
- R10: After `rst_n` the vector reads 0x00 and all flags and `irq` are low.
- R11: In one cycle, a raise of a source beats a clear of the same source. When several vector writes coincide, the priority is receive A, then transmit A, then receive B, then transmit B, and any of these beats a no-interrupt write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_rst | input | 2 | Per-channel reset pulse (bit 0 = A) |
| rx_set | input | 2 | Raise receive interrupt pulse |
| rx_clr | input | 2 | Clear receive interrupt pulse |
| tx_set | input | 2 | Raise transmit interrupt pulse |
| tx_clr | input | 2 | Clear transmit interrupt pulse |
| brk_status | input | 2 | Break status level per channel |
| tx_int_en | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, [1:0] A, [3:2] B |
| brk_int_en | input | 2 | Break interrupt enable per channel |
| vec_hi_sel | input | 1 | Vector encoding select, 1 = high form |
| cmd_valid | input | 1 | Command strobe |
| cmd_chan | input | 1 | Command target channel (0 = A) |
| cmd_byte | input | 8 | Command byte, field in bits 5:3 |
| rd_idx | input | 4 | Register index for read |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the two under-service flags of a channel are never both set, that each under-service flag implies its pending flag, and that every stored vector is one of the legal codes. They also check that an enabled break forces `irq`, that `irq` never rises without a cause, and that a channel reset empties that channel's pending bits on the next cycle. The bench scenarios cover the behaviours that depend on the history of events. These are the vector kept while the other source is under service, the ordering in reset-highest-under-service, the encoding captured at write time and not at read time, and the priority among events in the same cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NCH   = 2;
  localparam int VEC_W = 8;

  typedef enum logic [2:0] {
    SRC_RX_A = 3'd0,
    SRC_TX_A = 3'd1,
    SRC_RX_B = 3'd2,
    SRC_TX_B = 3'd3,
    SRC_NONE = 3'd4
  } vec_src_e;

  function automatic logic [VEC_W-1:0] vec_code(input logic hi, input vec_src_e src);
    logic [VEC_W-1:0] c;
    case (src)
      SRC_RX_A: c = hi ? 8'h30 : 8'h0C;
      SRC_TX_A: c = hi ? 8'h10 : 8'h08;
      SRC_RX_B: c = hi ? 8'h20 : 8'h04;
      SRC_TX_B: c = 8'h00;
      default:  c = hi ? 8'h60 : 8'h06;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic rx_set,
  input  logic rx_clr,
  input  logic tx_set,
  input  logic tx_clr,
  input  logic cmd_rst_ius,
  input  logic cmd_clr_tx,
  output logic rx_pend,
  output logic tx_pend,
  output logic rx_ius,
  output logic tx_ius,
  output logic take_rx,
  output logic take_tx,
  output logic clr_evt
);
  logic rx_clr_e, tx_clr_e;
  logic rx_ius_left, tx_ius_left;

  always_comb begin
    rx_clr_e    = rx_clr | (cmd_rst_ius & rx_ius);
    tx_clr_e    = tx_clr | cmd_clr_tx | (cmd_rst_ius & ~rx_ius & tx_ius);
    rx_ius_left = rx_ius & ~rx_clr_e;
    tx_ius_left = tx_ius & ~tx_clr_e;
    take_rx     = ~chan_rst & rx_set & ~tx_ius_left;
    take_tx     = ~chan_rst & tx_set & ~rx_ius_left & ~take_rx;
    clr_evt     = ~chan_rst & (rx_clr_e | tx_clr_e);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || chan_rst) begin
      rx_pend <= 1'b0;
      tx_pend <= 1'b0;
      rx_ius  <= 1'b0;
      tx_ius  <= 1'b0;
    end else begin
      rx_pend <= rx_set | (rx_pend & ~rx_clr_e);
      tx_pend <= tx_set | (tx_pend & ~tx_clr_e);
      rx_ius  <= take_rx | rx_ius_left;
      tx_ius  <= take_tx | tx_ius_left;
    end
  end
endmodule

// File: rtl/sio_vec_reg.sv
module sio_vec_reg
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_sel,
  input  logic [NCH-1:0]   take_rx,
  input  logic [NCH-1:0]   take_tx,
  input  logic [NCH-1:0]   clr_evt,
  output logic [VEC_W-1:0] vec_q
);
  logic     wr_en;
  vec_src_e src;

  always_comb begin
    wr_en = 1'b1;
    src   = SRC_NONE;
    if (take_rx[0])      src = SRC_RX_A;
    else if (take_tx[0]) src = SRC_TX_A;
    else if (take_rx[1]) src = SRC_RX_B;
    else if (take_tx[1]) src = SRC_TX_B;
    else if (|clr_evt)   src = SRC_NONE;
    else                 wr_en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     vec_q <= '0;
    else if (wr_en) vec_q <= vec_code(hi_sel, src);
  end
endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge
  import sio_irq_pkg::*;
(
  input  logic [NCH-1:0]   tx_int_en,
  input  logic [2*NCH-1:0] rx_mode,
  input  logic [NCH-1:0]   brk_int_en,
  input  logic [NCH-1:0]   brk_status,
  input  logic [NCH-1:0]   rx_pend,
  input  logic [NCH-1:0]   tx_pend,
  output logic             irq
);
  logic [NCH-1:0] chan_req;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0] mode;
    logic       rx_on;
    assign mode        = rx_mode[2*i +: 2];
    assign rx_on       = (mode == 2'b01) || (mode == 2'b10);
    assign chan_req[i] = (tx_int_en[i] & tx_pend[i])
                       | (rx_on & rx_pend[i])
                       | (brk_int_en[i] & brk_status[i]);
  end

  assign irq = |chan_req;
endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
  import sio_irq_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CMD_W    = 8,
  parameter int CMD_LSB  = 3,
  parameter int VEC_IDX  = 2,
  parameter int PEND_IDX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       chan_rst,
  input  logic [1:0]       rx_set,
  input  logic [1:0]       rx_clr,
  input  logic [1:0]       tx_set,
  input  logic [1:0]       tx_clr,
  input  logic [1:0]       brk_status,
  input  logic [1:0]       tx_int_en,
  input  logic [3:0]       rx_mode,
  input  logic [1:0]       brk_int_en,
  input  logic             vec_hi_sel,
  input  logic             cmd_valid,
  input  logic             cmd_chan,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             irq
);
  localparam logic [2:0] CMD_RST_IUS = 3'b111;
  localparam logic [2:0] CMD_CLR_TX  = 3'b101;

  logic [2:0]       cmd_field;
  logic [NCH-1:0]   cmd_rst_ius, cmd_clr_tx;
  logic [NCH-1:0]   rx_pend, tx_pend, rx_ius, tx_ius;
  logic [NCH-1:0]   take_rx, take_tx, clr_evt;
  logic [VEC_W-1:0] vec_q;
  logic [7:0]       pend_reg;

  assign cmd_field = cmd_byte[CMD_LSB +: 3];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit;
    assign hit            = cmd_valid && (cmd_chan == i[0]);
    assign cmd_rst_ius[i] = hit && (cmd_field == CMD_RST_IUS);
    assign cmd_clr_tx[i]  = hit && (cmd_field == CMD_CLR_TX);

    sio_irq_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_rst    (chan_rst[i]),
      .rx_set      (rx_set[i]),
      .rx_clr      (rx_clr[i]),
      .tx_set      (tx_set[i]),
      .tx_clr      (tx_clr[i]),
      .cmd_rst_ius (cmd_rst_ius[i]),
      .cmd_clr_tx  (cmd_clr_tx[i]),
      .rx_pend     (rx_pend[i]),
      .tx_pend     (tx_pend[i]),
      .rx_ius      (rx_ius[i]),
      .tx_ius      (tx_ius[i]),
      .take_rx     (take_rx[i]),
      .take_tx     (take_tx[i]),
      .clr_evt     (clr_evt[i])
    );
  end

  sio_vec_reg u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_sel  (vec_hi_sel),
    .take_rx (take_rx),
    .take_tx (take_tx),
    .clr_evt (clr_evt),
    .vec_q   (vec_q)
  );

  sio_irq_merge u_merge (
    .tx_int_en  (tx_int_en),
    .rx_mode    (rx_mode),
    .brk_int_en (brk_int_en),
    .brk_status (brk_status),
    .rx_pend    (rx_pend),
    .tx_pend    (tx_pend),
    .irq        (irq)
  );

  // R5: external/status bits 3 and 0 stay zero
  assign pend_reg = {2'b00, rx_pend[0], tx_pend[0], 1'b0, rx_pend[1], tx_pend[1], 1'b0};

  // R8: combinational read
  always_comb begin
    if (rd_idx == IDX_W'(VEC_IDX))       rd_data = vec_q;
    else if (rd_idx == IDX_W'(PEND_IDX)) rd_data = pend_reg;
    else                                 rd_data = '0;
  end
endmodule

// File: rtl/sio_irq_vector_chk.sv
module sio_irq_vector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_rst,
  input logic [1:0] brk_int_en,
  input logic [1:0] brk_status,
  input logic       irq,
  input logic [1:0] rx_pend,
  input logic [1:0] tx_pend,
  input logic [1:0] rx_ius,
  input logic [1:0] tx_ius,
  input logic [7:0] vec_q,
  input logic [7:0] pend_reg
);
  AST_IUS_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ius & tx_ius) == 2'b00); // R2
  AST_IUS_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_ius & ~rx_pend) | (tx_ius & ~tx_pend)) == 2'b00); // R2
  AST_BRK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(brk_int_en & brk_status)) |-> irq); // R1
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|rx_pend) || (|tx_pend) || (|(brk_int_en & brk_status)))); // R1
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60}); // R3
  AST_CHRST_A_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst[0] |=> pend_reg[5:4] == 2'b00); // R9
  AST_CHRST_B_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst[1] |=> pend_reg[2:1] == 2'b00); // R9
endmodule

bind sio_irq_vector sio_irq_vector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_rst   (chan_rst),
  .brk_int_en (brk_int_en),
  .brk_status (brk_status),
  .irq        (irq),
  .rx_pend    (rx_pend),
  .tx_pend    (tx_pend),
  .rx_ius     (rx_ius),
  .tx_ius     (tx_ius),
  .vec_q      (vec_q),
  .pend_reg   (pend_reg)
);

// File: tb/sio_irq_vector_test.sv
`timescale 1ns/1ps
module sio_irq_vector_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] chan_rst, rx_set, rx_clr, tx_set, tx_clr, brk_status, tx_int_en, brk_int_en;
  logic [3:0] rx_mode;
  logic       vec_hi_sel, cmd_valid, cmd_chan;
  logic [7:0] cmd_byte;
  logic [3:0] rd_idx;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sio_irq_vector uut (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .rx_set(rx_set), .rx_clr(rx_clr),
    .tx_set(tx_set), .tx_clr(tx_clr), .brk_status(brk_status), .tx_int_en(tx_int_en),
    .rx_mode(rx_mode), .brk_int_en(brk_int_en), .vec_hi_sel(vec_hi_sel),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_byte(cmd_byte),
    .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] v);
    rd_idx = idx;
    #0.1;
    v = rd_data;
  endtask

  task automatic chk_vec(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(4'd2, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_pend(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(4'd3, v);
    chk(tag, v, exp);
  endtask

  task automatic sys_reset();
    @(negedge clk);
    rst_n = 1'b0;
    chan_rst = '0; rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0;
    brk_status = '0; brk_int_en = '0; tx_int_en = 2'b11; rx_mode = 4'b0101;
    vec_hi_sel = 1'b0; cmd_valid = 1'b0; cmd_chan = 1'b0; cmd_byte = '0; rd_idx = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic [1:0] rs, input logic [1:0] rc, input logic [1:0] ts,
                       input logic [1:0] tc, input logic [1:0] cr);
    @(negedge clk);
    rx_set = rs; rx_clr = rc; tx_set = ts; tx_clr = tc; chan_rst = cr;
    @(negedge clk);
    rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0; chan_rst = '0;
  endtask

  task automatic command(input logic ch, input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_chan = ch; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = '0;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    sys_reset();
    chk_vec("R10 vector after reset", 8'h00);
    chk_pend("R10 pending after reset", 8'h00);
    chk("R10 irq after reset", {7'd0, irq}, 8'h00);
    rd(4'd5, v);
    chk("R8 unused index reads zero", v, 8'h00);
  endtask

  task automatic t_low_rx_b();
    sys_reset();
    pulse(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    pulse(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_vec("R4 rx B low code", 8'h04);
    chk_pend("R5 rx B at bit 2", 8'h04);
    chk("R1 rx pending mode 01 raises irq", {7'd0, irq}, 8'h01);
    command(1'b1, 8'h38);
    chk_vec("R7 clear writes low none code", 8'h06);
    chk_pend("R6 reset-IUS clears rx B", 8'h00);
    chk("R1 irq low after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_high_service();
    sys_reset();
    vec_hi_sel = 1'b1;
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_vec("R3 rx A high code", 8'h30);
    pulse(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    chk_vec("R2 tx A blocked while rx A in service", 8'h30);
    chk_pend("R5 rx A bit 5 and tx A bit 4", 8'h30);
    command(1'b0, 8'h38);
    chk_vec("R7 clear writes high none code", 8'h60);
    chk_pend("R6 reset-IUS clears rx first", 8'h10);
    command(1'b0, 8'h38);
    chk_pend("R6 reset-IUS with nothing in service", 8'h10);
    chk_vec("R6 vector unchanged by idle reset-IUS", 8'h60);
    command(1'b0, 8'h28);
    chk_pend("R6 clear-tx command", 8'h00);
    pulse(2'b00, 2'b00, 2'b10, 2'b00, 2'b00);
    chk_vec("R3 tx B code", 8'h00);
    pulse(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_vec("R2 rx B blocked while tx B in service", 8'h00);
    chk_pend("R2 rx B still pending", 8'h06);
  endtask

  task automatic t_high_cross();
    sys_reset();
    vec_hi_sel = 1'b1;
    pulse(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_vec("R3 rx B high code", 8'h20);
    pulse(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    chk_vec("R3 tx A high code, other channel not blocking", 8'h10);
  endtask

  task automatic t_low_codes();
    sys_reset();
    pulse(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    chk_vec("R4 tx A low code", 8'h08);
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_vec("R2 rx A blocked while tx A in service", 8'h08);
    sys_reset();
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_vec("R4 rx A low code", 8'h0C);
    vec_hi_sel = 1'b1;
    chk_vec("R4 stored code kept after select change", 8'h0C);
    pulse(2'b00, 2'b01, 2'b00, 2'b00, 2'b00);
    chk_vec("R7 none code follows current select", 8'h60);
    chk_pend("R5 rx A cleared", 8'h00);
  endtask

  task automatic t_irq_terms();
    sys_reset();
    tx_int_en = 2'b10;
    pulse(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    chk("R1 tx pending without enable", {7'd0, irq}, 8'h00);
    tx_int_en = 2'b11;
    #0.1;
    chk("R1 tx pending with enable", {7'd0, irq}, 8'h01);
    command(1'b0, 8'h28);
    pulse(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    rx_mode = 4'b1101;
    #0.1;
    chk("R1 rx mode 11 gives no irq", {7'd0, irq}, 8'h00);
    rx_mode = 4'b0001;
    #0.1;
    chk("R1 rx mode 00 gives no irq", {7'd0, irq}, 8'h00);
    rx_mode = 4'b1001;
    #0.1;
    chk("R1 rx mode 10 gives irq", {7'd0, irq}, 8'h01);
    command(1'b1, 8'h38);
    brk_status = 2'b01;
    #0.1;
    chk("R1 break without enable", {7'd0, irq}, 8'h00);
    brk_int_en = 2'b01;
    #0.1;
    chk("R1 break with enable", {7'd0, irq}, 8'h01);
    brk_status = 2'b00;
  endtask

  task automatic t_chan_reset();
    sys_reset();
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    pulse(2'b00, 2'b00, 2'b10, 2'b00, 2'b00);
    chk_vec("R4 tx B code after rx A", 8'h00);
    pulse(2'b00, 2'b00, 2'b00, 2'b00, 2'b10);
    chk_pend("R9 channel B reset keeps A", 8'h20);
    chk_vec("R9 vector untouched by channel reset", 8'h00);
    chk("R9 irq from remaining rx A", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_other_cmds();
    sys_reset();
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    command(1'b0, 8'h10);
    chk_pend("R6 unknown command ignored", 8'h20);
    chk_vec("R6 unknown command leaves vector", 8'h0C);
    command(1'b1, 8'h38);
    chk_pend("R6 command to B leaves A", 8'h20);
  endtask

  task automatic t_priority();
    sys_reset();
    pulse(2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
    chk_vec("R11 rx A beats rx B", 8'h0C);
    chk_pend("R11 both rx pending", 8'h24);
    sys_reset();
    pulse(2'b01, 2'b01, 2'b00, 2'b00, 2'b00);
    chk_pend("R11 raise beats clear of same source", 8'h20);
    pulse(2'b00, 2'b00, 2'b10, 2'b10, 2'b00);
    chk_vec("R11 tx B raise beats its clear in vector", 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_low_rx_b();
    t_high_service();
    t_high_cross();
    t_low_codes();
    t_irq_terms();
    t_chan_reset();
    t_other_cmds();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule